// File: doc/BRIEF.md
# Split-Register Interval Timer

This block is a 32-bit up-counter with a programmable terminal value. Software reaches it over a narrow 16-bit register bus. The terminal value is written as two 16-bit halves, and the running count is read back as two 16-bit halves. A hold register keeps the two count halves consistent with each other.

The timer has two run modes:
- **Wrapping mode** turns the counter into a periodic tick source: it counts from zero up to the terminal value, returns to zero and starts again.
- **Single-pass mode** counts up to the terminal value once, then parks there and clears its own mode bit. It acts as a one-shot event timer.

When the count equals the terminal value, an interrupt output pulses if the interrupt enable is set.

A new terminal value waits in a staging register. It is adopted only when the counter restarts or wraps, so a count that is under way is never disturbed by a write.

Top module: `split_interval_timer`

## Requirements
- R1: After reset the control register reads 0, the count reads 0, `irqOut` is low, and both halves of the staged terminal value read 0xFFFF.
- R2: The control register is at byte offset 0x00. Bit 0 selects wrapping mode, bit 1 selects single-pass mode, and bit 8 enables the interrupt. Reading 0x00 returns these three bits in those positions, with all other bits zero.
- R3: The staged terminal value is written and read at 0x08 (bits 15:0) and at 0x0C (bits 31:16).
- R4: The count is read at 0x10 (bits 15:0) and at 0x14 (bits 31:16). Each read returns data on `busRdata` one cycle after `busRdEn`. A read of 0x10 captures the upper count half, and a later read of 0x14 returns that captured half.
- R5: While wrapping mode is active, the count advances by one each cycle up to the terminal value. In the cycle after it is equal to the terminal value, the count is 0.
- R6: In single-pass mode without wrapping mode, the count reaches the terminal value and then holds there. Bit 1 reads back as 0 from the following cycle.
- R7: `irqOut` is high exactly in those cycles where a run mode is active, the count equals the terminal value, and bit 8 is set.
- R8: Writing 0 to the control register stops counting. The count then holds its value and `irqOut` stays low.
- R9: A control write that sets bit 0 or bit 1 while no run mode is active makes the count read 0 in the next cycle.
- R10: A write to 0x08 or 0x0C does not change the terminal value in use. The staged value is adopted only at a restart (R9) or a wrap (R5).
- R11: When bits 0 and 1 are both set, the counter wraps as in R5 and bit 1 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid the cycle after `busRdEn` |
| irqOut | output | 1 | Interrupt, high while the count sits at the terminal value with the interrupt enabled |

## Verification
The count is hidden inside the block, so a corrupt count first shows at the ports through `irqOut`. If the count drifts by even one, the interrupt pulse comes one or more cycles early or late. In wrapping mode this shows within one period.

A wrong terminal-value register, or a staged value adopted too early, shifts the pulse spacing at the next wrap. A failure to clear the single-pass bit produces a second interrupt after the pass has ended.

Every read returns a value on the following cycle. A stale upper-half capture therefore shows on the very next read of 0x14.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Register byte offsets (software-visible layout)
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_MAXLO = 'h08;
  localparam int OFF_MAXHI = 'h0C;
  localparam int OFF_CNTLO = 'h10;
  localparam int OFF_CNTHI = 'h14;

  // Control bit positions
  localparam int BIT_WRAP = 0;
  localparam int BIT_ONCE = 1;
  localparam int BIT_IRQ  = 8;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_MAXLO,
    RD_MAXHI,
    RD_CNTLO,
    RD_CNTHI,
    RD_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   restart;
    logic   wrap;
    logic   advance;
    logic   loadMaxLo;
    logic   loadMaxHi;
    logic   latchHigh;
    rdSel_e rdSel;
  } tmrStrobe_t;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        ctlBits,    // {irq, once, wrap} from write data
  input  logic              atMax,
  output tmrStrobe_t        strobe,
  output logic [BUS_W-1:0]  ctrlWord,
  output logic              periodicOn,
  output logic              oneShotOn,
  output logic              irqOut
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_MAXLO = ADDR_W'(OFF_MAXLO);
  localparam logic [ADDR_W-1:0] A_MAXHI = ADDR_W'(OFF_MAXHI);
  localparam logic [ADDR_W-1:0] A_CNTLO = ADDR_W'(OFF_CNTLO);
  localparam logic [ADDR_W-1:0] A_CNTHI = ADDR_W'(OFF_CNTHI);

  logic irqOn;
  logic running;
  logic hit;
  logic wrCtl;
  logic startReq;

  always_comb begin
    running  = periodicOn | oneShotOn;
    hit      = running & atMax;
    wrCtl    = busWrEn && (busAddr == A_CTRL);
    startReq = wrCtl && (ctlBits[0] | ctlBits[1]) && !running;

    strobe.restart   = startReq;
    strobe.wrap      = !startReq && hit && periodicOn;   // wrapping mode has priority
    strobe.advance   = !startReq && running && !hit;
    strobe.loadMaxLo = busWrEn && (busAddr == A_MAXLO);
    strobe.loadMaxHi = busWrEn && (busAddr == A_MAXHI);
    strobe.latchHigh = busRdEn && (busAddr == A_CNTLO);

    strobe.rdSel = RD_NONE;
    if (busRdEn) begin
      unique case (busAddr)
        A_CTRL:  strobe.rdSel = RD_CTRL;
        A_MAXLO: strobe.rdSel = RD_MAXLO;
        A_MAXHI: strobe.rdSel = RD_MAXHI;
        A_CNTLO: strobe.rdSel = RD_CNTLO;
        A_CNTHI: strobe.rdSel = RD_CNTHI;
        default: strobe.rdSel = RD_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodicOn <= 1'b0;
      oneShotOn  <= 1'b0;
      irqOn      <= 1'b0;
    end else if (wrCtl) begin
      periodicOn <= ctlBits[0];
      oneShotOn  <= ctlBits[1];
      irqOn      <= ctlBits[2];
    end else if (hit && !periodicOn) begin
      oneShotOn  <= 1'b0;                 // single pass done
    end
  end

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[BIT_WRAP] = periodicOn;
    ctrlWord[BIT_ONCE] = oneShotOn;
    ctrlWord[BIT_IRQ]  = irqOn;
  end

  assign irqOut = hit & irqOn;

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int              CNT_W     = 32,
  parameter logic [CNT_W-1:0] RESET_MAX = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tmrStrobe_t            strobe,
  input  logic [CNT_W/2-1:0]    busWdata,
  input  logic [CNT_W/2-1:0]    ctrlWord,
  output logic                  atMax,
  output logic [CNT_W/2-1:0]    busRdata,
  output logic [CNT_W-1:0]      cntVal,
  output logic [CNT_W-1:0]      maxActVal
);

  localparam int HALF_W = CNT_W / 2;
  localparam int N_HALF = 2;

  logic [CNT_W-1:0]  maxPend;
  logic [HALF_W-1:0] hiHold;
  logic [N_HALF-1:0] halfLoad;

  assign halfLoad = {strobe.loadMaxHi, strobe.loadMaxLo};

  // Staged terminal value, one register per bus-sized half
  for (genvar h = 0; h < N_HALF; h++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN)
        maxPend[h*HALF_W +: HALF_W] <= RESET_MAX[h*HALF_W +: HALF_W];
      else if (halfLoad[h])
        maxPend[h*HALF_W +: HALF_W] <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal    <= '0;
      maxActVal <= RESET_MAX;
    end else if (strobe.restart || strobe.wrap) begin
      cntVal    <= '0;
      maxActVal <= maxPend;
    end else if (strobe.advance) begin
      cntVal    <= cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      hiHold <= '0;
    else if (strobe.latchHigh)
      hiHold <= cntVal[CNT_W-1:HALF_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else begin
      unique case (strobe.rdSel)
        RD_NONE:  busRdata <= busRdata;
        RD_CTRL:  busRdata <= ctrlWord;
        RD_MAXLO: busRdata <= maxPend[HALF_W-1:0];
        RD_MAXHI: busRdata <= maxPend[CNT_W-1:HALF_W];
        RD_CNTLO: busRdata <= cntVal[HALF_W-1:0];
        RD_CNTHI: busRdata <= hiHold;
        default:  busRdata <= '0;
      endcase
    end
  end

  assign atMax = (cntVal == maxActVal);

endmodule

// File: rtl/split_interval_timer.sv
module split_interval_timer
  import timer_pkg::*;
#(
  parameter int               CNT_W     = 32,
  parameter int               ADDR_W    = 5,
  parameter logic [CNT_W-1:0] RESET_MAX = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [CNT_W/2-1:0]  busWdata,
  output logic [CNT_W/2-1:0]  busRdata,
  output logic                irqOut
);

  localparam int BUS_W = CNT_W / 2;

  tmrStrobe_t       strobe;
  logic [BUS_W-1:0] ctrlWord;
  logic             atMax;
  logic             periodicOn;
  logic             oneShotOn;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] maxActVal;
  logic [2:0]       ctlBits;

  assign ctlBits = {busWdata[BIT_IRQ], busWdata[BIT_ONCE], busWdata[BIT_WRAP]};

  timer_ctrl #(
    .ADDR_W(ADDR_W),
    .BUS_W (BUS_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .ctlBits   (ctlBits),
    .atMax     (atMax),
    .strobe    (strobe),
    .ctrlWord  (ctrlWord),
    .periodicOn(periodicOn),
    .oneShotOn (oneShotOn),
    .irqOut    (irqOut)
  );

  timer_datapath #(
    .CNT_W    (CNT_W),
    .RESET_MAX(RESET_MAX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .ctrlWord (ctrlWord),
    .atMax    (atMax),
    .busRdata (busRdata),
    .cntVal   (cntVal),
    .maxActVal(maxActVal)
  );

endmodule

// File: rtl/timer_sva_chk.sv
module timer_sva_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        runBits,
  input logic              irqOut,
  input logic              atMax,
  input logic              periodicOn,
  input logic              oneShotOn,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  maxActVal
);

  logic wrCtl;
  logic running;
  assign wrCtl   = busWrEn && (busAddr == '0);
  assign running = periodicOn | oneShotOn;

  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl && (runBits != 2'b00) && !running) |=> (cntVal == '0));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodicOn && atMax) |=> (cntVal == '0));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !atMax) |=> (cntVal == $past(cntVal) + 1'b1));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !wrCtl) |=> $stable(cntVal));

  // R6
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotOn && !periodicOn && atMax && !wrCtl) |=> (!oneShotOn && $stable(cntVal)));

  // R7
  irq_at_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (running && atMax));

  // R10
  max_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !atMax) |=> $stable(maxActVal));

  // R11
  both_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodicOn && oneShotOn && !wrCtl) |=> oneShotOn);

endmodule

bind split_interval_timer timer_sva_chk #(
  .CNT_W (CNT_W),
  .ADDR_W(ADDR_W)
) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .runBits   (busWdata[1:0]),
  .irqOut    (irqOut),
  .atMax     (atMax),
  .periodicOn(periodicOn),
  .oneShotOn (oneShotOn),
  .cntVal    (cntVal),
  .maxActVal (maxActVal)
);

// File: tb/tb_split_interval_timer.sv
`timescale 1ns/1ps
module tb_split_interval_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irqOut;

  always #5 clk = ~clk;   // 100 MHz

  split_interval_timer dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // Behavioural reference state
  logic [31:0] mCnt, mMaxAct, mMaxPend;
  logic [15:0] mHi, expRd;
  logic        mWrap, mOnce, mIrq, expValid;
  int          checks = 0, fails = 0, cycles = 0;
  bit          done = 0;
  string       phase = "R1";

  always @(posedge clk) begin
    logic run, hit, wc;
    if (!rstN) begin
      mCnt = 0; mMaxAct = '1; mMaxPend = '1; mHi = 0;
      mWrap = 0; mOnce = 0; mIrq = 0; expValid = 0; expRd = 0;
    end else begin
      run = mWrap | mOnce;
      hit = run && (mCnt == mMaxAct);
      wc  = busWrEn && busAddr == 5'h00;
      expValid = busRdEn;
      if (busRdEn) begin
        case (busAddr)
          5'h00: expRd = {7'b0, mIrq, 6'b0, mOnce, mWrap};
          5'h08: expRd = mMaxPend[15:0];
          5'h0C: expRd = mMaxPend[31:16];
          5'h10: begin expRd = mCnt[15:0]; mHi = mCnt[31:16]; end
          5'h14: expRd = mHi;
          default: expRd = 0;
        endcase
      end
      if (wc && (busWdata[0] | busWdata[1]) && !run) begin
        mCnt = 0; mMaxAct = mMaxPend;
      end else if (hit && mWrap) begin
        mCnt = 0; mMaxAct = mMaxPend;
      end else if (!hit && run) begin
        mCnt = mCnt + 1;
      end
      if (wc) begin
        mWrap = busWdata[0]; mOnce = busWdata[1]; mIrq = busWdata[8];
      end else if (hit && !mWrap) begin
        mOnce = 0;
      end
      if (busWrEn && busAddr == 5'h08) mMaxPend[15:0]  = busWdata;
      if (busWrEn && busAddr == 5'h0C) mMaxPend[31:16] = busWdata;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    logic expIrq;
    if (rstN && !done) begin
      expIrq = (mWrap | mOnce) && (mCnt == mMaxAct) && mIrq;
      checks++;
      if (irqOut !== expIrq) begin
        fails++;
        $display("FAIL R7/%s irqOut actual=%0b expected=%0b t=%0t", phase, irqOut, expIrq, $time);
      end
      if (expValid) begin
        checks++;
        if (busRdata !== expRd) begin
          fails++;
          $display("FAIL %s/R4 busRdata actual=%h expected=%h t=%0t", phase, busRdata, expRd, $time);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); busWrEn = 1; busAddr = a; busWdata = d;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk); busRdEn = 1; busAddr = a;
    @(negedge clk); busRdEn = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset values
    phase = "R1";
    rd(5'h00); rd(5'h08); rd(5'h0C); rd(5'h10); rd(5'h14);
    // R3: staged terminal value readback
    phase = "R3";
    wr(5'h08, 16'd5); wr(5'h0C, 16'd0); rd(5'h08); rd(5'h0C);
    // R5 / R9 / R2: wrapping with interrupt
    phase = "R5";
    wr(5'h00, 16'h0101); rd(5'h00);
    for (int i = 0; i < 12; i++) rd(5'h10);
    // R10: stage a new value mid-count, takes effect only at wrap
    phase = "R10";
    wr(5'h08, 16'd3);
    for (int i = 0; i < 14; i++) rd(5'h10);
    // R8: stop, count holds, no interrupt
    phase = "R8";
    wr(5'h00, 16'h0000);
    for (int i = 0; i < 6; i++) rd(5'h10);
    // R9 + R6: single pass from idle restarts at zero
    phase = "R6";
    wr(5'h08, 16'd7);
    wr(5'h00, 16'h0102);
    for (int i = 0; i < 8; i++) rd(5'h10);
    rd(5'h00); idle(5); rd(5'h00); rd(5'h10);
    // R6: single pass with interrupt masked
    phase = "R9";
    wr(5'h00, 16'h0002); idle(12); rd(5'h00); rd(5'h10);
    // R11: both bits, wrapping wins
    phase = "R11";
    wr(5'h08, 16'd4); wr(5'h00, 16'h0000);
    wr(5'h00, 16'h0103); idle(20); rd(5'h00); rd(5'h10);
    // R4: upper half capture across 16-bit boundary
    phase = "R4";
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0010); wr(5'h0C, 16'h0001);
    wr(5'h00, 16'h0101);
    idle(65540);
    rd(5'h10); idle(3); rd(5'h14);
    idle(20);
    rd(5'h10); rd(5'h14);
    wr(5'h00, 16'h0000);
    rd(5'h10); idle(2); rd(5'h14);
    idle(3);
    done = 1;
    summary();
    $finish;
  end

endmodule